// File: doc/BRIEF.md
# Accumulator Round, Window and Clamp Output Stage

This block turns a wide accumulator word into a narrow output sample. In the same cycle it adds a programmable offset, picks a 16-bit slice of the 32-bit sum, and can clamp that slice between two signed bounds. The result goes into an output register that can be frozen. Sixteen offset words and sixteen bound-pair words sit in two small register files. Each file is written through a simple one-word write port, and the current input cycle selects which entry is read.

A filter datapath drives the accumulator input every cycle and sets the selectors next to it. Rounding is a choice of offset value: half of the output LSB gives round-to-nearest, and a zero entry turns rounding off. The slice code sets the output scaling. The bound pair keeps results inside a legal pixel or sample range.

Top module: `acc_post_stage`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dout` becomes 0, every offset entry becomes 0 and every bound entry becomes upper 16'h7FFF / lower 16'h8000, which is the full signed range.
- R2: The selected offset entry (`rnd_sel`) is added to `acc_in` modulo 2^32, with no saturation, before the slice is taken.
- R3: For `win_code` n from 0 to 16, the slice is bits 15+n down to n of the 32-bit sum.
- R4: `win_code` values 17 to 31 give the same slice as 16, which is bits 31..16.
- R5: When `clamp_n` is 0, the slice is compared as signed 16-bit against the entry chosen by `lim_sel`. The lower bound is bits 15..0 and the upper bound is bits 31..16. A slice below the lower bound outputs the lower bound, and a slice above the upper bound outputs the upper bound. A slice equal to either bound passes. The upper bound must be the larger of the two.
- R6: When `clamp_n` is 1, the slice passes unchanged.
- R7: When `oload_n` is 1, `dout` keeps its value. When it is 0, `dout` takes the new result at that clock edge, one cycle after the inputs are presented.
- R8: When `cfg_we` is 1 at an edge, `cfg_wdata` is written to entry `cfg_idx`. If `cfg_kind` is 0 the offset file is written, and if it is 1 the bound file is written. Other entries and the other file do not change.
- R9: A write takes effect for loads from the next edge onward. A load in the same cycle as a write to the selected entry uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_in | input | 32 | Accumulator word, two's complement |
| rnd_sel | input | 4 | Offset entry select |
| win_code | input | 5 | Output slice code |
| lim_sel | input | 4 | Bound entry select |
| clamp_n | input | 1 | Clamp enable, active low |
| oload_n | input | 1 | Output register load enable, active low |
| cfg_we | input | 1 | Register file write strobe |
| cfg_kind | input | 1 | Write target: 0 offset file, 1 bound file |
| cfg_idx | input | 4 | Write entry index |
| cfg_wdata | input | 32 | Write data; bound words are upper in 31..16 and lower in 15..0 |
| dout | output | 16 | Registered output sample |

## Verification
A register file write and an output load can happen at the same edge on the same entry. The bench provokes this by writing a new offset while `rnd_sel` points at that entry and `oload_n` is low. It expects the sample loaded at that edge to use the old offset and the next sample to use the new one. The same overlap is repeated for a bound entry with clamping on. Around these cases, sweeps over every slice code, offset entry and clamp setting on several accumulator words are compared with an arithmetic model kept in the bench.

// File: rtl/acc_post_pkg.sv
// Package: shared sizes and the write-target encoding of the
// accumulator post-processing stage.
// Assumes the output slice is narrower than the accumulator.
package acc_post_pkg;
    localparam int ACC_W_DEF  = 32;
    localparam int OUT_W_DEF  = 16;
    localparam int NREG_DEF   = 16;
    localparam int CODE_W_DEF = 5;

    typedef enum logic {
        CFG_ROUND = 1'b0,
        CFG_LIMIT = 1'b1
    } cfg_kind_e;
endpackage

// File: rtl/post_regfile.sv
// Module: small register file with one synchronous write port and one
// combinational read port.
// Assumes reset is synchronous and active low; every entry resets to
// RESET_VAL. A read of the entry written at an edge returns the old
// value until that edge.
module post_regfile #(
    parameter int          NREG      = 16,
    parameter int          W         = 32,
    parameter logic [W-1:0] RESET_VAL = '0,
    localparam int         IDX_W     = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] mem [NREG];

    // Reset all entries, else write the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                mem[i] <= RESET_VAL;
            end
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Read the selected entry.
    always_comb begin
        rdata = mem[ridx];
    end
endmodule

// File: rtl/post_window.sv
// Module: adds an offset to the accumulator word (wrapping) and picks
// an OUT_W-bit slice of the sum by code.
// Assumes CODE_W can hold ACC_W-OUT_W; codes above that saturate to the
// top slice.
module post_window #(
    parameter int ACC_W  = 32,
    parameter int OUT_W  = 16,
    parameter int CODE_W = 5,
    localparam int MAX_SHIFT = ACC_W - OUT_W,
    localparam int NWIN      = MAX_SHIFT + 1
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic [ACC_W-1:0]  offset,
    input  logic [CODE_W-1:0] code,
    output logic [OUT_W-1:0]  win
);
    logic [ACC_W-1:0]  sum;
    logic [OUT_W-1:0]  win_arr [NWIN];
    logic [CODE_W-1:0] code_eff;

    // Wrapping add of the offset.
    always_comb begin
        sum = acc + offset;
    end

    // One slice per legal code.
    for (genvar g = 0; g < NWIN; g++) begin : g_slice
        assign win_arr[g] = sum[g + OUT_W - 1 : g];
    end

    // Saturate out-of-range codes and select the slice.
    always_comb begin
        code_eff = (code > CODE_W'(MAX_SHIFT)) ? CODE_W'(MAX_SHIFT) : code;
        win      = win_arr[code_eff];
    end
endmodule

// File: rtl/post_clamp.sv
// Module: optional signed clamp of a sample between a lower bound
// (bounds low half) and an upper bound (bounds high half).
// Assumes the upper bound is not below the lower bound; en_n is active low.
module post_clamp #(
    parameter int OUT_W = 16
) (
    input  logic [OUT_W-1:0]   val,
    input  logic [2*OUT_W-1:0] bounds,
    input  logic               en_n,
    output logic [OUT_W-1:0]   res
);
    logic signed [OUT_W-1:0] s_val;
    logic signed [OUT_W-1:0] s_lo;
    logic signed [OUT_W-1:0] s_hi;

    // Unpack bounds and clamp when enabled.
    always_comb begin
        s_val = val;
        s_lo  = bounds[OUT_W-1:0];
        s_hi  = bounds[2*OUT_W-1:OUT_W];
        if (en_n) begin
            res = val;
        end else if (s_val < s_lo) begin
            res = s_lo;
        end else if (s_val > s_hi) begin
            res = s_hi;
        end else begin
            res = val;
        end
    end
endmodule

// File: rtl/acc_post_stage.sv
// Module: top of the accumulator output stage: offset file, bound file,
// add-and-slice, clamp, and a holdable output register.
// Assumes synchronous active-low reset and a single clock for data and
// register writes. Latency from inputs to dout is one edge.
module acc_post_stage
    import acc_post_pkg::*;
#(
    parameter int ACC_W  = ACC_W_DEF,
    parameter int OUT_W  = OUT_W_DEF,
    parameter int NREG   = NREG_DEF,
    parameter int CODE_W = CODE_W_DEF,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic [SEL_W-1:0]  rnd_sel,
    input  logic [CODE_W-1:0] win_code,
    input  logic [SEL_W-1:0]  lim_sel,
    input  logic              clamp_n,
    input  logic              oload_n,
    input  logic              cfg_we,
    input  logic              cfg_kind,
    input  logic [SEL_W-1:0]  cfg_idx,
    input  logic [ACC_W-1:0]  cfg_wdata,
    output logic [OUT_W-1:0]  dout
);
    localparam logic [2*OUT_W-1:0] LIM_FULL =
        {1'b0, {(OUT_W-1){1'b1}}, 1'b1, {(OUT_W-1){1'b0}}};

    logic               we_rnd;
    logic               we_lim;
    logic [ACC_W-1:0]   rnd_word;
    logic [2*OUT_W-1:0] lim_word;
    logic [OUT_W-1:0]   win_val;
    logic [OUT_W-1:0]   clamp_val;

    // Route the write strobe to the addressed file.
    always_comb begin
        we_rnd = cfg_we && (cfg_kind_e'(cfg_kind) == CFG_ROUND);
        we_lim = cfg_we && (cfg_kind_e'(cfg_kind) == CFG_LIMIT);
    end

    post_regfile #(
        .NREG(NREG), .W(ACC_W), .RESET_VAL('0)
    ) rnd_file_i (
        .clk(clk), .rst_n(rst_n), .we(we_rnd), .widx(cfg_idx),
        .wdata(cfg_wdata), .ridx(rnd_sel), .rdata(rnd_word)
    );

    post_regfile #(
        .NREG(NREG), .W(2*OUT_W), .RESET_VAL(LIM_FULL)
    ) lim_file_i (
        .clk(clk), .rst_n(rst_n), .we(we_lim), .widx(cfg_idx),
        .wdata(cfg_wdata[2*OUT_W-1:0]), .ridx(lim_sel), .rdata(lim_word)
    );

    post_window #(
        .ACC_W(ACC_W), .OUT_W(OUT_W), .CODE_W(CODE_W)
    ) window_i (
        .acc(acc_in), .offset(rnd_word), .code(win_code), .win(win_val)
    );

    post_clamp #(
        .OUT_W(OUT_W)
    ) clamp_i (
        .val(win_val), .bounds(lim_word), .en_n(clamp_n), .res(clamp_val)
    );

    // Output register: clear on reset, load when oload_n is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (!oload_n) begin
            dout <= clamp_val;
        end
    end
endmodule

// File: rtl/acc_post_chk.sv
// Module: property checker for acc_post_stage, attached by bind.
// Assumes it sees the read words of both register files.
module acc_post_chk #(
    parameter int ACC_W  = 32,
    parameter int OUT_W  = 16,
    parameter int CODE_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ACC_W-1:0]   acc_in,
    input logic [CODE_W-1:0]  win_code,
    input logic               clamp_n,
    input logic               oload_n,
    input logic [OUT_W-1:0]   dout,
    input logic [ACC_W-1:0]   rnd_word,
    input logic [2*OUT_W-1:0] lim_word
);
    logic [ACC_W-1:0] chk_sum;
    logic             bounds_ok;

    // Reference sum and bound ordering for the properties.
    always_comb begin
        chk_sum   = acc_in + rnd_word;
        bounds_ok = $signed(lim_word[2*OUT_W-1:OUT_W]) >= $signed(lim_word[OUT_W-1:0]);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> dout == '0); // R1

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        oload_n |=> $stable(dout)); // R7

    AST_CLAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!oload_n && !clamp_n && bounds_ok) |=>
        ($signed(dout) >= $signed($past(lim_word[OUT_W-1:0])) &&
         $signed(dout) <= $signed($past(lim_word[2*OUT_W-1:OUT_W])))); // R5

    AST_PASS_LOW_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
        (!oload_n && clamp_n && win_code == '0) |=>
        dout == $past(chk_sum[OUT_W-1:0])); // R6

    AST_TOP_CODE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!oload_n && clamp_n && win_code > CODE_W'(ACC_W-OUT_W)) |=>
        dout == $past(chk_sum[ACC_W-1:ACC_W-OUT_W])); // R4
endmodule

bind acc_post_stage acc_post_chk #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .CODE_W(CODE_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .win_code(win_code),
    .clamp_n(clamp_n), .oload_n(oload_n), .dout(dout),
    .rnd_word(rnd_word), .lim_word(lim_word)
);

// File: tb/acc_post_stage_tb_top.sv
// Bench: directed cases plus a sweep of slice code, offset entry and
// clamp setting, compared with an arithmetic model.
module acc_post_stage_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] acc_in = '0;
    logic [3:0]  rnd_sel = '0;
    logic [4:0]  win_code = '0;
    logic [3:0]  lim_sel = '0;
    logic        clamp_n = 1'b1;
    logic        oload_n = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_kind = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] dout;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] rnd_m [16];
    logic [31:0] lim_m [16];

    acc_post_stage dut_i (
        .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .rnd_sel(rnd_sel),
        .win_code(win_code), .lim_sel(lim_sel), .clamp_n(clamp_n),
        .oload_n(oload_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .dout(dout)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] model(input logic [31:0] a, input logic [3:0] rs,
                                          input logic [4:0] c, input logic [3:0] ls,
                                          input logic cn);
        logic [31:0] s;
        int          n;
        logic signed [15:0] w, lo, hi;
        s  = a + rnd_m[rs];
        n  = (c > 5'd16) ? 16 : int'(c);
        w  = 16'(s >> n);
        lo = lim_m[ls][15:0];
        hi = lim_m[ls][31:16];
        if (!cn && w < lo) w = lo;
        else if (!cn && w > hi) w = hi;
        return w;
    endfunction

    task automatic check(input string req, input logic [15:0] exp);
        n_vec++;
        if (dout !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, dout, exp);
        end
    endtask

    task automatic step(input logic [31:0] a, input logic [3:0] rs, input logic [4:0] c,
                        input logic [3:0] ls, input logic cn, input logic ol);
        @(negedge clk);
        acc_in = a; rnd_sel = rs; win_code = c; lim_sel = ls; clamp_n = cn; oload_n = ol;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic kind, input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = kind; cfg_idx = idx; cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        if (kind) lim_m[idx] = d; else rnd_m[idx] = d;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL R7 watchdog actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] held;
        logic [31:0] accs [5];
        accs[0] = 32'h0000_0000; accs[1] = 32'h7FFF_FFFF; accs[2] = 32'h8000_0001;
        accs[3] = 32'h1234_5678; accs[4] = 32'hFEDC_BA98;
        for (int i = 0; i < 16; i++) begin
            rnd_m[i] = '0;
            lim_m[i] = 32'h7FFF_8000;
        end
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset dout", 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: default offset zero and full-range bounds.
        step(32'h0000_9ABC, 4'd7, 5'd0, 4'd3, 1'b0, 1'b0);
        check("R1 default entries", 16'h9ABC);
        step(32'h8001_0000, 4'd12, 5'd16, 4'd9, 1'b0, 1'b0);
        check("R1 default bounds top slice", 16'h8001);

        // Load the files with bench-chosen contents (R8).
        for (int i = 0; i < 16; i++) begin
            wr(1'b0, 4'(i), (i == 0) ? 32'h0 : (i == 15) ? 32'hFFFF_FFFF
                            : 32'(i) * 32'h0F1E_2D3C + 32'(i) * 32'h0000_8000);
            wr(1'b1, 4'(i), {16'(i * 1500 + 100), 16'(-(i * 2000))});
        end
        // R8: entries written are distinct; check a couple through outputs.
        step(32'h0, 4'd15, 5'd0, 4'd0, 1'b1, 1'b0);
        check("R8 offset entry 15", 16'hFFFF);
        step(32'h0, 4'd0, 5'd0, 4'd0, 1'b1, 1'b0);
        check("R8 offset entry 0", 16'h0000);

        // R2: wrap-around of the add.
        step(32'h0000_0001, 4'd15, 5'd0, 4'd0, 1'b1, 1'b0);
        check("R2 wrap low", 16'h0000);
        step(32'h0000_0001, 4'd15, 5'd16, 4'd0, 1'b1, 1'b0);
        check("R2 wrap high", 16'h0000);

        // R5: exact-bound boundaries with bounds -5 / +5 in entry 5.
        wr(1'b1, 4'd5, {16'sd5, -16'sd5});
        step(-32'sd6, 4'd0, 5'd0, 4'd5, 1'b0, 1'b0); check("R5 below lower", 16'hFFFB);
        step(-32'sd5, 4'd0, 5'd0, 4'd5, 1'b0, 1'b0); check("R5 at lower", 16'hFFFB);
        step(32'sd5,  4'd0, 5'd0, 4'd5, 1'b0, 1'b0); check("R5 at upper", 16'h0005);
        step(32'sd6,  4'd0, 5'd0, 4'd5, 1'b0, 1'b0); check("R5 above upper", 16'h0005);
        step(32'sd6,  4'd0, 5'd0, 4'd5, 1'b1, 1'b0); check("R6 clamp off", 16'h0006);

        // R7: hold keeps dout while inputs change.
        held = dout;
        step(32'hAAAA_5555, 4'd3, 5'd4, 4'd2, 1'b1, 1'b1); check("R7 hold 1", held);
        step(32'h1357_9BDF, 4'd9, 5'd0, 4'd1, 1'b0, 1'b1); check("R7 hold 2", held);

        // R9: write and load of the same entry at the same edge.
        @(negedge clk);
        acc_in = 32'd100; rnd_sel = 4'd2; win_code = 5'd0; lim_sel = 4'd0;
        clamp_n = 1'b1; oload_n = 1'b0;
        cfg_we = 1'b1; cfg_kind = 1'b0; cfg_idx = 4'd2; cfg_wdata = 32'd5;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        check("R9 same-edge offset uses old", 16'(32'd100 + rnd_m[2]));
        rnd_m[2] = 32'd5;
        step(32'd100, 4'd2, 5'd0, 4'd0, 1'b1, 1'b0);
        check("R9 offset next edge", 16'd105);
        @(negedge clk);
        acc_in = 32'd50; rnd_sel = 4'd0; lim_sel = 4'd5; clamp_n = 1'b0; oload_n = 1'b0;
        cfg_we = 1'b1; cfg_kind = 1'b1; cfg_idx = 4'd5; cfg_wdata = {16'sd40, 16'sd0};
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        check("R9 same-edge bound uses old", 16'h0005);
        lim_m[5] = {16'sd40, 16'sd0};
        step(32'd50, 4'd0, 5'd0, 4'd5, 1'b0, 1'b0);
        check("R9 bound next edge", 16'd40);

        // R3 R4 R5 R6 R2: sweep codes, offset entries and clamp modes.
        for (int k = 0; k < 5; k++) begin
            for (int c = 0; c < 32; c++) begin
                for (int r = 0; r < 16; r++) begin
                    for (int cn = 0; cn < 2; cn++) begin
                        step(accs[k], 4'(r), 5'(c), 4'(r ^ c), 1'(cn), 1'b0);
                        check((c > 16) ? "R4 sweep" : (cn != 0) ? "R3 sweep" : "R5 sweep",
                              model(accs[k], 4'(r), 5'(c), 4'(r ^ c), 1'(cn)));
                    end
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule